// File: doc/BRIEF.md
# Atomic Bit-Operation GPIO Port

This block is a 32-pin general-purpose I/O port that sits on a memory-mapped word bus. Software chooses the pins it drives through a direction register, writes the drive levels through an output latch, and samples the pins through a synchronised input register. Its three atomic registers let software raise, lower or invert any group of output bits with one bus write, with no read-modify-write sequence.

A write to an atomic register places the written mask in a one-cycle staging register. On the next clock edge the mask is folded into the output latch, and the staging register returns to zero by itself. The port occupies an eight-word window whose base is a parameter. Every request that falls inside the window is answered one cycle later with a ready pulse, and a new request may be issued on every cycle.

Top module: `gpio_atomic_port`

## Requirements
- R1: A request whose word address lies in the eight-word window at `BASE` (aligned to eight words) raises `bus_rdy` on the following cycle, with `bus_rdata` valid in that same cycle. A request outside the window never raises `bus_rdy` and changes no state. Requests may arrive on consecutive cycles.
- R2: The word offset within the window selects the register: 0 direction, 1 output latch, 2 atomic set, 3 atomic clear, 4 atomic toggle, 6 synchronised input. Offsets 5 and 7 read as zero, and writes to them have no effect.
- R3: A write to the direction register or the output latch replaces the whole register at the clock edge that ends the request cycle. A later read returns the written value.
- R4: A write to an atomic register holds the mask for one cycle and applies it at the next edge. The output therefore changes on the second edge after the request, after which the atomic register is zero again. Reads of the atomic offsets return zero.
- R5: Each 1 in a mask written to the set register drives the matching output bit to 1. Bits written as 0 keep their value.
- R6: Each 1 in a mask written to the clear register drives the matching output bit to 0. Bits written as 0 keep their value.
- R7: Each 1 in a mask written to the toggle register inverts the matching output bit. Bits written as 0 keep their value.
- R8: When a pending atomic mask and a plain write to the output latch fall in the same cycle, the mask is applied to the newly written value.
- R9: `pin_oe` equals the direction register, where 1 marks an output. `pin_out` equals the output latch ANDed with the direction register, so a pin set as an input drives 0 and is not enabled.
- R10: The input register returns `pin_in` after a two-flop synchroniser. A level applied before edge E1 is first returned by a read request that is captured at edge E3.
- R11: After reset all registers are zero, every pin is an input, and the output latch is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus request, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data, valid with bus_rdy |
| bus_rdy | output | 1 | Ready, one cycle after an accepted request |
| pin_in | input | W | Asynchronous pin levels |
| pin_out | output | W | Pin drive value |
| pin_oe | output | W | Pin output enable |

## Verification
The collision that matters is between a staged atomic mask and a plain write to the output latch. Both reach the latch at the same edge when an atomic write is followed directly by an output-latch write. The bench issues such back-to-back pairs for set, clear and toggle. It expects the mask composed over the new value, and it also checks back-to-back set-then-clear pairs. A long sweep of mixed operations on varying masks is compared against an arithmetic model of the latch. The model is sampled both one edge after each atomic write (unchanged) and two edges after it (updated).

// File: rtl/gpio_atom_pkg.sv
`timescale 1ns/1ps
package gpio_atom_pkg;

    // Word offset inside the port window
    localparam int unsigned SEL_W = 3;

    // Depth of the input synchroniser
    localparam int unsigned SYNC_DEPTH = 2;

    typedef enum logic [SEL_W-1:0] {
        OFS_DIR  = 3'd0,
        OFS_OUT  = 3'd1,
        OFS_SET  = 3'd2,
        OFS_CLR  = 3'd3,
        OFS_TOG  = 3'd4,
        OFS_RSV5 = 3'd5,
        OFS_IN   = 3'd6,
        OFS_RSV7 = 3'd7
    } reg_sel_e;

    // Decoded write strobes, one per writable register
    typedef struct packed {
        logic wr_dir;
        logic wr_out;
        logic wr_set;
        logic wr_clr;
        logic wr_tog;
    } wr_strobe_t;

    localparam wr_strobe_t NO_WRITE = '{default: 1'b0};

    function automatic wr_strobe_t decode_write(input logic wr, input reg_sel_e sel);
        wr_strobe_t s;
        s        = NO_WRITE;
        s.wr_dir = wr && (sel == OFS_DIR);
        s.wr_out = wr && (sel == OFS_OUT);
        s.wr_set = wr && (sel == OFS_SET);
        s.wr_clr = wr && (sel == OFS_CLR);
        s.wr_tog = wr && (sel == OFS_TOG);
        return s;
    endfunction

endpackage

// File: rtl/gpio_bus_decode.sv
`timescale 1ns/1ps
module gpio_bus_decode
    import gpio_atom_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'h0200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output wr_strobe_t        strb,
    output reg_sel_e          rd_sel,
    output logic              rd_en,
    output logic              rdy
);
    localparam int unsigned TAG_W = ADDR_W - SEL_W;
    localparam logic [TAG_W-1:0] BASE_TAG = BASE[ADDR_W-1:SEL_W];

    logic     hit;
    reg_sel_e sel;

    always_comb begin
        hit    = req && (addr[ADDR_W-1:SEL_W] == BASE_TAG);
        sel    = reg_sel_e'(addr[SEL_W-1:0]);
        strb   = decode_write(hit && we, sel);
        rd_sel = sel;
        rd_en  = hit && !we;
    end

    always_ff @(posedge clk) begin
        if (rst) rdy <= 1'b0;
        else     rdy <= hit;
    end
endmodule

// File: rtl/gpio_atomic_stage.sv
`timescale 1ns/1ps
module gpio_atomic_stage
    import gpio_atom_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  wr_strobe_t   strb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] set_m,
    output logic [W-1:0] clr_m,
    output logic [W-1:0] tog_m
);
    // Each mask lives for exactly one cycle, then self-clears
    always_ff @(posedge clk) begin
        if (rst) begin
            set_m <= '0;
            clr_m <= '0;
            tog_m <= '0;
        end else begin
            set_m <= strb.wr_set ? wdata : '0;
            clr_m <= strb.wr_clr ? wdata : '0;
            tog_m <= strb.wr_tog ? wdata : '0;
        end
    end
endmodule

// File: rtl/gpio_out_latch.sv
`timescale 1ns/1ps
module gpio_out_latch #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_dir,
    input  logic         wr_out,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] set_m,
    input  logic [W-1:0] clr_m,
    input  logic [W-1:0] tog_m,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] out_q
);
    logic [W-1:0] base_v;
    logic [W-1:0] out_d;

    // A plain write sets the base; staged masks compose on top of it
    always_comb begin
        base_v = wr_out ? wdata : out_q;
        out_d  = ((base_v | set_m) & ~clr_m) ^ tog_m;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            out_q <= '0;
        end else begin
            if (wr_dir) dir_q <= wdata;
            out_q <= out_d;
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] sync_q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= pin_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign sync_q = chain[STAGES-1];
endmodule

// File: rtl/gpio_atomic_port.sv
`timescale 1ns/1ps
module gpio_atomic_port
    import gpio_atom_pkg::*;
#(
    parameter int unsigned W      = 32,
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'h0200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              bus_rdy,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe
);
    wr_strobe_t   strb;
    reg_sel_e     rd_sel;
    logic         rd_en;
    logic [W-1:0] set_m, clr_m, tog_m;
    logic [W-1:0] dir_q, out_q;
    logic [W-1:0] in_sync;
    logic [W-1:0] rdata_q;

    gpio_bus_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .clk(clk), .rst(rst), .req(bus_req), .we(bus_we), .addr(bus_addr),
        .strb(strb), .rd_sel(rd_sel), .rd_en(rd_en), .rdy(bus_rdy)
    );

    gpio_atomic_stage #(.W(W)) u_atom (
        .clk(clk), .rst(rst), .strb(strb), .wdata(bus_wdata),
        .set_m(set_m), .clr_m(clr_m), .tog_m(tog_m)
    );

    gpio_out_latch #(.W(W)) u_latch (
        .clk(clk), .rst(rst), .wr_dir(strb.wr_dir), .wr_out(strb.wr_out),
        .wdata(bus_wdata), .set_m(set_m), .clr_m(clr_m), .tog_m(tog_m),
        .dir_q(dir_q), .out_q(out_q)
    );

    gpio_in_sync #(.W(W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst(rst), .pin_in(pin_in), .sync_q(in_sync)
    );

    // Registered read mux; atomic and reserved offsets read as zero
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            case (rd_sel)
                OFS_DIR: rdata_q <= dir_q;
                OFS_OUT: rdata_q <= out_q;
                OFS_IN:  rdata_q <= in_sync;
                default: rdata_q <= '0;
            endcase
        end else begin
            rdata_q <= '0;
        end
    end

    assign bus_rdata = rdata_q;
    assign pin_oe    = dir_q;
    assign pin_out   = out_q & dir_q;
endmodule

// File: rtl/gpio_atomic_port_chk.sv
`timescale 1ns/1ps
module gpio_atomic_port_chk
    import gpio_atom_pkg::*;
#(
    parameter int unsigned W      = 32,
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'h0200
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic              bus_rdy,
    input logic [W-1:0]      pin_out,
    input logic [W-1:0]      pin_oe,
    input logic [W-1:0]      out_q,
    input logic [W-1:0]      set_m,
    input logic [W-1:0]      clr_m,
    input logic [W-1:0]      tog_m
);
    logic in_win;
    logic [SEL_W-1:0] ofs;
    assign in_win = bus_req && (bus_addr[ADDR_W-1:SEL_W] == BASE[ADDR_W-1:SEL_W]);
    assign ofs    = bus_addr[SEL_W-1:0];

    a_r1_rdy_after_hit: assert property (@(posedge clk) disable iff (rst)
        in_win |=> bus_rdy);

    a_r1_no_rdy_on_miss: assert property (@(posedge clk) disable iff (rst)
        !in_win |=> !bus_rdy);

    a_r3_dir_write: assert property (@(posedge clk) disable iff (rst)
        (in_win && bus_we && ofs == OFS_DIR) |=> (pin_oe == $past(bus_wdata)));

    a_r4_set_from_write: assert property (@(posedge clk) disable iff (rst)
        (set_m != '0) |-> $past(in_win && bus_we && ofs == OFS_SET));

    a_r4_tog_from_write: assert property (@(posedge clk) disable iff (rst)
        (tog_m != '0) |-> $past(in_win && bus_we && ofs == OFS_TOG));

    a_r5_set_lands: assert property (@(posedge clk) disable iff (rst)
        (set_m != '0) |=> ((out_q & $past(set_m)) == $past(set_m)));

    a_r6_clr_lands: assert property (@(posedge clk) disable iff (rst)
        (clr_m != '0) |=> ((out_q & $past(clr_m)) == '0));

    a_r7_tog_lands: assert property (@(posedge clk) disable iff (rst)
        (tog_m != '0 && !(in_win && bus_we && ofs == OFS_OUT))
        |=> (((out_q ^ $past(out_q)) & $past(tog_m)) == $past(tog_m)));

    a_r9_inputs_quiet: assert property (@(posedge clk) disable iff (rst)
        ((pin_out & ~pin_oe) == '0));
endmodule

bind gpio_atomic_port gpio_atomic_port_chk #(.W(W), .ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdy(bus_rdy), .pin_out(pin_out), .pin_oe(pin_oe),
    .out_q(out_q), .set_m(set_m), .clr_m(clr_m), .tog_m(tog_m)
);

// File: tb/test_gpio_atomic_port.sv
`timescale 1ns/1ps
module test_gpio_atomic_port;
    localparam int unsigned W  = 32;
    localparam int unsigned AW = 16;
    localparam logic [AW-1:0] BASE = 16'h0200;

    localparam logic [2:0] O_DIR = 3'd0, O_OUT = 3'd1, O_SET = 3'd2,
                           O_CLR = 3'd3, O_TOG = 3'd4, O_R5 = 3'd5,
                           O_IN = 3'd6, O_R7 = 3'd7;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_req, bus_we;
    logic [AW-1:0] bus_addr;
    logic [W-1:0]  bus_wdata, bus_rdata, pin_in, pin_out, pin_oe;
    logic          bus_rdy;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    gpio_atomic_port #(.W(W), .ADDR_W(AW), .BASE(BASE)) i_gpio_atomic_port (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rdy(bus_rdy), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] ofs, input logic [W-1:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = BASE + AW'(ofs); bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] ofs, output logic [W-1:0] d, output logic r);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = BASE + AW'(ofs);
        @(negedge clk);
        d = bus_rdata; r = bus_rdy;
        bus_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] d, ex, dir, p;
        logic r;
        rst = 1'b1; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0;
        bus_wdata = '0; pin_in = '0;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R11 reset state
        chk("R11 pin_oe", pin_oe, '0);
        chk("R11 pin_out", pin_out, '0);
        chk("R11 rdy", {31'd0, bus_rdy}, '0);
        rd(O_DIR, d, r); chk("R11 dir read", d, '0);
        rd(O_OUT, d, r); chk("R11 out read", d, '0);

        // R3 direction write and readback, R1 ready
        dir = 32'hFFFF_FFFF;
        wr(O_DIR, dir);
        chk("R9 oe follows dir", pin_oe, dir);
        rd(O_DIR, d, r);
        chk("R3 dir readback", d, dir);
        chk("R1 rdy on read", {31'd0, r}, 32'd1);

        // Sweep of mixed operations against arithmetic model
        ex = '0;
        p  = 32'h1357_9BDF;
        for (int k = 0; k < 48; k++) begin
            p = p * 32'h0019_660D + 32'h3C6E_F35F;
            case (k % 4)
                0: begin
                    wr(O_SET, p);
                    chk("R4 set not yet applied", pin_out, ex);
                    ex = ex | p; idle(1);
                    chk("R5 set result", pin_out, ex);
                end
                1: begin
                    wr(O_CLR, p);
                    chk("R4 clear not yet applied", pin_out, ex);
                    ex = ex & ~p; idle(1);
                    chk("R6 clear result", pin_out, ex);
                end
                2: begin
                    wr(O_TOG, p);
                    chk("R4 toggle not yet applied", pin_out, ex);
                    ex = ex ^ p; idle(1);
                    chk("R7 toggle result", pin_out, ex);
                end
                default: begin
                    wr(O_OUT, p);
                    ex = p;
                    chk("R3 plain write at once", pin_out, ex);
                end
            endcase
            rd(O_OUT, d, r);
            chk("R3 out readback", d, ex);
        end

        // R4 atomic offsets read zero, R2 reserved offsets
        rd(O_SET, d, r); chk("R4 set reads zero", d, '0);
        rd(O_CLR, d, r); chk("R4 clear reads zero", d, '0);
        rd(O_TOG, d, r); chk("R4 toggle reads zero", d, '0);
        wr(O_R5, 32'hFFFF_FFFF);
        wr(O_R7, 32'h0000_0000);
        idle(2);
        rd(O_R5, d, r); chk("R2 offset 5 reads zero", d, '0);
        chk("R2 offset 5 rdy", {31'd0, r}, 32'd1);
        rd(O_R7, d, r); chk("R2 offset 7 reads zero", d, '0);
        rd(O_OUT, d, r); chk("R2 reserved write ignored out", d, ex);
        rd(O_DIR, d, r); chk("R2 reserved write ignored dir", d, dir);

        // R1 out-of-window request
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = BASE + 16'd9; bus_wdata = ~ex;
        @(negedge clk);
        chk("R1 no rdy above window", {31'd0, bus_rdy}, '0);
        bus_addr = BASE - 16'd7;
        @(negedge clk);
        chk("R1 no rdy below window", {31'd0, bus_rdy}, '0);
        bus_req = 1'b0; bus_we = 1'b0;
        idle(2);
        chk("R1 miss leaves latch", pin_out, ex);

        // R8 staged mask meets plain write
        wr(O_OUT, 32'h0F0F_0000);
        wr(O_SET, 32'h0000_00F0);
        wr(O_OUT, 32'hA5A5_A5A5);
        ex = 32'hA5A5_A5A5 | 32'h0000_00F0;
        chk("R8 set over new write", pin_out, ex);
        wr(O_CLR, 32'hFF00_0000);
        wr(O_OUT, 32'h1234_5678);
        ex = 32'h1234_5678 & ~32'hFF00_0000;
        chk("R8 clear over new write", pin_out, ex);
        wr(O_TOG, 32'h0000_FFFF);
        wr(O_OUT, 32'hCAFE_0101);
        ex = 32'hCAFE_0101 ^ 32'h0000_FFFF;
        chk("R8 toggle over new write", pin_out, ex);

        // R4 back-to-back atomics, one per cycle
        wr(O_SET, 32'hF000_000F);
        wr(O_CLR, 32'h8000_0001);
        wr(O_TOG, 32'h0000_0F00);
        idle(1);
        ex = (((ex | 32'hF000_000F) & ~32'h8000_0001) ^ 32'h0000_0F00);
        chk("R4 back-to-back atomics", pin_out, ex);

        // R9 partial direction
        dir = 32'h0000_FFFF;
        wr(O_DIR, dir);
        chk("R9 oe partial", pin_oe, dir);
        chk("R9 input pins drive zero", pin_out, ex & dir);
        rd(O_OUT, d, r); chk("R9 latch kept", d, ex);

        // R10 synchroniser latency
        for (int j = 0; j < 4; j++) begin
            logic [W-1:0] old_v, new_v;
            old_v = pin_in;
            new_v = 32'h8421_1248 * (j + 3) ^ 32'h5A5A_0F0F;
            pin_in = new_v;
            rd(O_IN, d, r); chk("R10 capture at E1 old", d, old_v);
            rd(O_IN, d, r); chk("R10 capture at E2 old", d, old_v);
            rd(O_IN, d, r); chk("R10 capture at E3 new", d, new_v);
        end

        // R11 reset mid-run
        rst = 1'b1; idle(2); rst = 1'b0; idle(1);
        chk("R11 reset clears oe", pin_oe, '0);
        rd(O_OUT, d, r); chk("R11 reset clears latch", d, '0);

        finish_run();
    end
endmodule